// File: doc/BRIEF.md
# Synchronous Dual-Port Lane-Split RAM

This block is a two-port synchronous static RAM whose word is split into two lanes: an 8-bit byte lane (word bits 7..0) and a 1-bit extra lane (word bit 8). Each port has its own address, data input, active-low chip select and active-low clock enable. Each port also has a read/write select and an output enable for each lane. Address, data and control are captured in input registers on the rising clock edge. A captured write is committed to the array on the following edge. A captured read loads a per-port output register on the following edge.

The two lanes of a port are steered independently, so one lane can be written while the other is read in the same command. Each lane's output models a tri-state driver as data plus a drive flag. The flag reacts to the lane's output enable at once, with no clock. An undriven lane presents zero data. The number of words is set by `ADDR_W` (default 1024 words; `ADDR_W = 12` gives 4096). Both ports run from one shared clock, so the rule for simultaneous access to one address is well defined.

Top module: `ldp_ram`

## Requirements
- R1: A word holds 9 bits: byte lane = bits 7..0, extra lane = bit 8. A word written through either port reads back unchanged through either port.
- R2: Inputs are captured on the rising edge. Read data of a command captured at edge N appears on the port's data output, with its drive flags high, after edge N+1.
- R3: While a port's clock enable (active low) is high, the command on that port is not captured. The output register and the drive flags keep their values.
- R4: A lane is written when chip select is low and that lane's read/write select is 0. The value is committed at the edge after capture. A select of 1 reads the lane.
- R5: The lanes are independent. A command may write one lane and read the other; the lane that is not written keeps its old value.
- R6: With chip select high, no lane is written and both drive flags are low after the next edge, whatever the read/write selects and data are.
- R7: A lane's output enable (active low) acts without a clock: when high, the lane's drive flag is 0 and its data bits are 0. A lane whose captured command is a write is also undriven during that cycle.
- R8: The setup flag of a port is 1 for one cycle after the capture of a write to a lane whose previous captured read/write select was 1. This includes the first capture after reset. The flag is 0 when every written lane was 0 at the previous capture.
- R9: When both ports write the same lane of the same address in one cycle, port A's value is stored. The choice is made per lane.
- R10: A read by one port of an address that the other port writes in the same cycle returns the old contents.
- R11: During reset, all drive flags and setup flags are 0 and all data outputs are 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_clken_n | input | 1 | Port A clock enable, active low |
| a_byte_rw | input | 1 | Port A byte lane select, 1 read / 0 write |
| a_bit_rw | input | 1 | Port A extra lane select, 1 read / 0 write |
| a_byte_oe_n | input | 1 | Port A byte lane output enable, active low |
| a_bit_oe_n | input | 1 | Port A extra lane output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | 9 | Port A write data |
| a_dout | output | 9 | Port A read data, zero on undriven lanes |
| a_byte_drv | output | 1 | Port A byte lane driven |
| a_bit_drv | output | 1 | Port A extra lane driven |
| a_setup_err | output | 1 | Port A write setup violation |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_clken_n | input | 1 | Port B clock enable, active low |
| b_byte_rw | input | 1 | Port B byte lane select, 1 read / 0 write |
| b_bit_rw | input | 1 | Port B extra lane select, 1 read / 0 write |
| b_byte_oe_n | input | 1 | Port B byte lane output enable, active low |
| b_bit_oe_n | input | 1 | Port B extra lane output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | 9 | Port B write data |
| b_dout | output | 9 | Port B read data, zero on undriven lanes |
| b_byte_drv | output | 1 | Port B byte lane driven |
| b_bit_drv | output | 1 | Port B extra lane driven |
| b_setup_err | output | 1 | Port B write setup violation |

## Verification
The bench writes one lane and reads the other in the same command. A design that merged the lane controls would overwrite the extra bit or drop its read. It stalls a port with the clock enable while a write is presented and toggles an output enable with no clock edge. A design that ignored the stall would store the write or lose the held data; one that registered the enable would change the flag only at the next edge. It writes both ports to one address, and reads an address while the other port writes it. A wrong priority or a write-through path would show the losing port's value or the new data. The bench also checks deselect cycles that carry write selects, and the setup flag both with and without the preparatory cycle. Seeded random writes then mix lanes and ports and are compared with an array model.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  localparam int NUM_PORTS = 2;
  localparam int NUM_LANES = 2;
  localparam int LANE_BYTE = 0;
  localparam int LANE_BIT  = 1;
endpackage

// File: rtl/ldp_port_front.sv
module ldp_port_front #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 9,
  parameter int NL     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              clken_n,
  input  logic [NL-1:0]     rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] din_q,
  output logic [NL-1:0]     wen,
  output logic [NL-1:0]     rd_req,
  output logic              setup_err
);
  logic [ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0] din_d;
  logic              sel_q, sel_d;
  logic [NL-1:0]     wr_q, wr_d;
  logic              new_q, new_d;
  logic              err_q, err_d;

  always_comb begin
    addr_d = addr_q;
    din_d  = din_q;
    sel_d  = sel_q;
    wr_d   = wr_q;
    new_d  = 1'b0;
    err_d  = 1'b0;
    if (!clken_n) begin
      addr_d = addr;
      din_d  = din;
      sel_d  = !cs_n;
      wr_d   = ~rw;
      new_d  = 1'b1;
      err_d  = !cs_n && (|(~rw & ~wr_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= '0;
      sel_q  <= 1'b0;
      wr_q   <= '0;
      new_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      din_q  <= din_d;
      sel_q  <= sel_d;
      wr_q   <= wr_d;
      new_q  <= new_d;
      err_q  <= err_d;
    end
  end

  assign wen       = {NL{new_q & sel_q}} & wr_q;
  assign rd_req    = {NL{new_q & sel_q}} & ~wr_q;
  assign setup_err = err_q;

  // R3
  front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clken_n |=> ($stable(addr_q) && $stable(din_q) && !new_q));
endmodule

// File: rtl/ldp_array.sv
module ldp_array #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 9,
  parameter int BYTE_W = 8,
  parameter int NP     = 2,
  parameter int NL     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NP-1:0][ADDR_W-1:0]    addr,
  input  logic [NP-1:0][WORD_W-1:0]    din,
  input  logic [NP-1:0][NL-1:0]        wen,
  output logic [NP-1:0][WORD_W-1:0]    rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int LO = (l == 0) ? 0 : BYTE_W;
    localparam int LW = (l == 0) ? BYTE_W : WORD_W - BYTE_W;

    logic [LW-1:0] mem [DEPTH];

    // lower port index written last: port A wins a collision
    always_ff @(posedge clk) begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (wen[p][l]) mem[addr[p]] <= din[p][LO +: LW];
      end
    end

    for (genvar p = 0; p < NP; p++) begin : g_rd
      assign rdata[p][LO +: LW] = mem[addr[p]];
    end

    // R9
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wen[0][l] && wen[1][l] && (addr[0] == addr[1]))
      |=> (mem[$past(addr[0])] == $past(din[0][LO +: LW])));
  end
endmodule

// File: rtl/ldp_port_out.sv
module ldp_port_out #(
  parameter int WORD_W = 9,
  parameter int BYTE_W = 8,
  parameter int NL     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clken_n,
  input  logic [NL-1:0]     rd_req,
  input  logic [NL-1:0]     wr_act,
  input  logic [WORD_W-1:0] rdata,
  input  logic [NL-1:0]     oe_n,
  output logic [WORD_W-1:0] dout,
  output logic [NL-1:0]     drv
);
  logic [WORD_W-1:0] rd_q, rd_d;
  logic [NL-1:0]     vld_q, vld_d;

  always_comb begin
    rd_d  = rd_q;
    vld_d = vld_q;
    if (!clken_n) begin
      rd_d  = rdata;
      vld_d = rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      vld_q <= '0;
    end else begin
      rd_q  <= rd_d;
      vld_q <= vld_d;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int LO = (l == 0) ? 0 : BYTE_W;
    localparam int LW = (l == 0) ? BYTE_W : WORD_W - BYTE_W;

    assign drv[l]           = vld_q[l] & ~oe_n[l] & ~wr_act[l];
    assign dout[LO +: LW]   = drv[l] ? rd_q[LO +: LW] : '0;

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clken_n && !rd_req[l]) |=> !drv[l]);

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clken_n |=> ($stable(rd_q[LO +: LW]) && $stable(vld_q[l])));
  end
endmodule

// File: rtl/ldp_ram.sv
module ldp_ram
  import ldp_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BYTE_W  = 8,
  parameter int EXTRA_W = 1,
  localparam int WORD_W = BYTE_W + EXTRA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_clken_n,
  input  logic              a_byte_rw,
  input  logic              a_bit_rw,
  input  logic              a_byte_oe_n,
  input  logic              a_bit_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_din,
  output logic [WORD_W-1:0] a_dout,
  output logic              a_byte_drv,
  output logic              a_bit_drv,
  output logic              a_setup_err,
  input  logic              b_cs_n,
  input  logic              b_clken_n,
  input  logic              b_byte_rw,
  input  logic              b_bit_rw,
  input  logic              b_byte_oe_n,
  input  logic              b_bit_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_din,
  output logic [WORD_W-1:0] b_dout,
  output logic              b_byte_drv,
  output logic              b_bit_drv,
  output logic              b_setup_err
);
  localparam int NP = NUM_PORTS;
  localparam int NL = NUM_LANES;

  logic [NP-1:0]              cs_n_v, clken_v, err_v;
  logic [NP-1:0][NL-1:0]      rw_v, oe_v, wen_v, rdreq_v, drv_v;
  logic [NP-1:0][ADDR_W-1:0]  addr_v, addr_q_v;
  logic [NP-1:0][WORD_W-1:0]  din_v, din_q_v, rdata_v, dout_v;

  assign cs_n_v  = {b_cs_n, a_cs_n};
  assign clken_v = {b_clken_n, a_clken_n};
  assign addr_v  = {b_addr, a_addr};
  assign din_v   = {b_din, a_din};

  assign rw_v[0][LANE_BYTE] = a_byte_rw;
  assign rw_v[0][LANE_BIT]  = a_bit_rw;
  assign rw_v[1][LANE_BYTE] = b_byte_rw;
  assign rw_v[1][LANE_BIT]  = b_bit_rw;
  assign oe_v[0][LANE_BYTE] = a_byte_oe_n;
  assign oe_v[0][LANE_BIT]  = a_bit_oe_n;
  assign oe_v[1][LANE_BYTE] = b_byte_oe_n;
  assign oe_v[1][LANE_BIT]  = b_bit_oe_n;

  for (genvar p = 0; p < NP; p++) begin : g_port
    ldp_port_front #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NL(NL)) i_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n_v[p]),
      .clken_n   (clken_v[p]),
      .rw        (rw_v[p]),
      .addr      (addr_v[p]),
      .din       (din_v[p]),
      .addr_q    (addr_q_v[p]),
      .din_q     (din_q_v[p]),
      .wen       (wen_v[p]),
      .rd_req    (rdreq_v[p]),
      .setup_err (err_v[p])
    );

    ldp_port_out #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NL(NL)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .clken_n (clken_v[p]),
      .rd_req  (rdreq_v[p]),
      .wr_act  (wen_v[p]),
      .rdata   (rdata_v[p]),
      .oe_n    (oe_v[p]),
      .dout    (dout_v[p]),
      .drv     (drv_v[p])
    );
  end

  ldp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .NP(NP), .NL(NL)) i_array (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr_q_v),
    .din   (din_q_v),
    .wen   (wen_v),
    .rdata (rdata_v)
  );

  assign a_dout      = dout_v[0];
  assign a_byte_drv  = drv_v[0][LANE_BYTE];
  assign a_bit_drv   = drv_v[0][LANE_BIT];
  assign a_setup_err = err_v[0];
  assign b_dout      = dout_v[1];
  assign b_byte_drv  = drv_v[1][LANE_BYTE];
  assign b_bit_drv   = drv_v[1][LANE_BIT];
  assign b_setup_err = err_v[1];
endmodule

// File: tb/test_ldp_ram.sv
`timescale 1ns/1ps
module test_ldp_ram;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic a_cs_n, a_clken_n, a_byte_rw, a_bit_rw, a_byte_oe_n, a_bit_oe_n;
  logic b_cs_n, b_clken_n, b_byte_rw, b_bit_rw, b_byte_oe_n, b_bit_oe_n;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [8:0] a_din, b_din, a_dout, b_dout;
  logic a_byte_drv, a_bit_drv, a_setup_err, b_byte_drv, b_bit_drv, b_setup_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [8:0] model [DEPTH];

  always #4 clk = ~clk;

  ldp_ram #(.ADDR_W(ADDR_W)) i_ldp_ram (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_clken_n(a_clken_n), .a_byte_rw(a_byte_rw), .a_bit_rw(a_bit_rw),
    .a_byte_oe_n(a_byte_oe_n), .a_bit_oe_n(a_bit_oe_n), .a_addr(a_addr), .a_din(a_din),
    .a_dout(a_dout), .a_byte_drv(a_byte_drv), .a_bit_drv(a_bit_drv), .a_setup_err(a_setup_err),
    .b_cs_n(b_cs_n), .b_clken_n(b_clken_n), .b_byte_rw(b_byte_rw), .b_bit_rw(b_bit_rw),
    .b_byte_oe_n(b_byte_oe_n), .b_bit_oe_n(b_bit_oe_n), .b_addr(b_addr), .b_din(b_din),
    .b_dout(b_dout), .b_byte_drv(b_byte_drv), .b_bit_drv(b_bit_drv), .b_setup_err(b_setup_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int p, input logic cs_n, input logic byte_rw, input logic bit_rw,
                       input logic [ADDR_W-1:0] addr, input logic [8:0] din);
    if (p == 0) begin
      a_cs_n = cs_n; a_byte_rw = byte_rw; a_bit_rw = bit_rw; a_addr = addr; a_din = din;
    end else begin
      b_cs_n = cs_n; b_byte_rw = byte_rw; b_bit_rw = bit_rw; b_addr = addr; b_din = din;
    end
  endtask

  task automatic idle(input int p);
    drive(p, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic sample(input int p, output logic [8:0] d, output logic bd, output logic td);
    if (p == 0) begin d = a_dout; bd = a_byte_drv; td = a_bit_drv; end
    else        begin d = b_dout; bd = b_byte_drv; td = b_bit_drv; end
  endtask

  task automatic write_word(input int p, input logic [ADDR_W-1:0] addr, input logic [8:0] data,
                            input logic ben, input logic ten);
    drive(p, 1'b1, ~ben, ~ten, addr, data);
    tick();
    drive(p, 1'b0, ~ben, ~ten, addr, data);
    tick();
    idle(p);
    tick();
    if (ben) model[addr][7:0] = data[7:0];
    if (ten) model[addr][8]   = data[8];
  endtask

  task automatic read_word(input int p, input logic [ADDR_W-1:0] addr, output logic [8:0] d,
                           output logic bd, output logic td);
    drive(p, 1'b0, 1'b1, 1'b1, addr, '0);
    tick();
    idle(p);
    tick();
    sample(p, d, bd, td);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a_clken_n = 1'b0; b_clken_n = 1'b0;
    a_byte_oe_n = 1'b0; a_bit_oe_n = 1'b0; b_byte_oe_n = 1'b0; b_bit_oe_n = 1'b0;
    idle(0); idle(1);
    repeat (3) @(negedge clk);
    check("R11", "a drive flags", {a_byte_drv, a_bit_drv}, 2'b00);
    check("R11", "b drive flags", {b_byte_drv, b_bit_drv}, 2'b00);
    check("R11", "data outs", {a_dout, b_dout}, 18'h0);
    check("R11", "setup flags", {a_setup_err, b_setup_err}, 2'b00);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_basic();
    logic [8:0] d; logic bd, td;
    write_word(0, 10'h005, 9'h1A5, 1'b1, 1'b1);
    read_word(0, 10'h005, d, bd, td);
    check("R1", "A readback", d, 9'h1A5);
    check("R2", "A drive flags after read", {bd, td}, 2'b11);
    write_word(1, 10'h3FF, 9'h05A, 1'b1, 1'b1);
    read_word(0, 10'h3FF, d, bd, td);
    check("R4", "B write read on A", d, 9'h05A);
    // R2: read data not yet present one edge after capture
    drive(0, 1'b0, 1'b1, 1'b1, 10'h005, '0);
    tick();
    idle(0);
    check("R2", "no early drive", {a_byte_drv, a_bit_drv}, 2'b00);
    tick();
    check("R2", "data after second edge", a_dout, 9'h1A5);
  endtask

  task automatic t_setup();
    // R8: write without preparatory cycle
    idle(0);
    tick();
    drive(0, 1'b0, 1'b0, 1'b1, 10'h020, 9'h0C3);
    tick();
    check("R8", "flag without prep", a_setup_err, 1'b1);
    idle(0);
    tick();
    model[10'h020][7:0] = 8'hC3;
    check("R8", "flag one cycle", a_setup_err, 1'b0);
    drive(0, 1'b1, 1'b0, 1'b0, 10'h020, 9'h13C);
    tick();
    drive(0, 1'b0, 1'b0, 1'b0, 10'h020, 9'h13C);
    tick();
    check("R8", "flag with prep", a_setup_err, 1'b0);
    idle(0);
    tick();
    model[10'h020] = 9'h13C;
  endtask

  task automatic t_mixed();
    logic [8:0] d; logic bd, td;
    write_word(0, 10'h040, 9'h1F0, 1'b1, 1'b1);
    drive(0, 1'b1, 1'b0, 1'b1, 10'h040, 9'h00F);
    tick();
    drive(0, 1'b0, 1'b0, 1'b1, 10'h040, 9'h00F);
    tick();
    idle(0);
    tick();
    check("R5", "bit lane read in mixed cmd", {a_bit_drv, a_dout[8]}, 2'b11);
    check("R5", "byte lane undriven in mixed cmd", a_byte_drv, 1'b0);
    model[10'h040][7:0] = 8'h0F;
    read_word(1, 10'h040, d, bd, td);
    check("R5", "word after mixed", d, 9'h10F);
  endtask

  task automatic t_writing_lane();
    drive(0, 1'b0, 1'b1, 1'b1, 10'h040, '0);
    tick();
    drive(0, 1'b0, 1'b0, 1'b1, 10'h040, 9'h0AA);
    tick();
    check("R7", "writing byte lane undriven", a_byte_drv, 1'b0);
    check("R7", "reading bit lane driven", {a_bit_drv, a_dout[8]}, 2'b11);
    idle(0);
    tick();
    model[10'h040][7:0] = 8'hAA;
  endtask

  task automatic t_stall_oe();
    logic [8:0] d; logic bd, td;
    drive(0, 1'b0, 1'b1, 1'b1, 10'h040, '0);
    tick();
    idle(0);
    tick();
    a_clken_n = 1'b1;
    drive(0, 1'b0, 1'b0, 1'b0, 10'h040, 9'h055);
    tick();
    tick();
    check("R3", "held data while stalled", a_dout, 9'h1AA);
    check("R3", "held drive while stalled", {a_byte_drv, a_bit_drv}, 2'b11);
    a_byte_oe_n = 1'b1;
    #1;
    check("R7", "byte drive off by enable", a_byte_drv, 1'b0);
    check("R7", "byte data zero when off", a_dout, 9'h100);
    a_bit_oe_n = 1'b1;
    a_byte_oe_n = 1'b0;
    #1;
    check("R7", "bit off byte back", {a_byte_drv, a_bit_drv, a_dout}, {2'b10, 9'h0AA});
    a_bit_oe_n = 1'b0;
    idle(0);
    a_clken_n = 1'b0;
    tick();
    tick();
    read_word(0, 10'h040, d, bd, td);
    check("R3", "stalled write ignored", d, 9'h1AA);
  endtask

  task automatic t_deselect();
    logic [8:0] d; logic bd, td;
    drive(0, 1'b1, 1'b0, 1'b0, 10'h040, 9'h000);
    tick();
    idle(0);
    tick();
    check("R6", "deselect undriven", {a_byte_drv, a_bit_drv}, 2'b00);
    read_word(0, 10'h040, d, bd, td);
    check("R6", "deselect no write", d, model[10'h040]);
  endtask

  task automatic t_collide();
    logic [8:0] d; logic bd, td;
    drive(0, 1'b1, 1'b0, 1'b1, 10'h077, 9'h0AA);
    drive(1, 1'b1, 1'b0, 1'b0, 10'h077, 9'h155);
    tick();
    drive(0, 1'b0, 1'b0, 1'b1, 10'h077, 9'h0AA);
    drive(1, 1'b0, 1'b0, 1'b0, 10'h077, 9'h155);
    tick();
    idle(0); idle(1);
    tick();
    model[10'h077] = 9'h1AA;
    read_word(0, 10'h077, d, bd, td);
    check("R9", "port A wins per lane", d, 9'h1AA);
  endtask

  task automatic t_rd_during_wr();
    logic [8:0] d; logic bd, td;
    write_word(0, 10'h099, 9'h0E1, 1'b1, 1'b1);
    drive(0, 1'b1, 1'b0, 1'b0, 10'h099, 9'h11E);
    tick();
    drive(0, 1'b0, 1'b0, 1'b0, 10'h099, 9'h11E);
    drive(1, 1'b0, 1'b1, 1'b1, 10'h099, '0);
    tick();
    idle(0); idle(1);
    tick();
    check("R10", "old data on other port", {b_byte_drv, b_bit_drv, b_dout}, {2'b11, 9'h0E1});
    model[10'h099] = 9'h11E;
    read_word(1, 10'h099, d, bd, td);
    check("R10", "new data afterwards", d, 9'h11E);
  endtask

  task automatic t_random();
    logic [8:0] d; logic bd, td;
    for (int i = 0; i < 16; i++) write_word(0, ADDR_W'(i), 9'(i * 37), 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) begin
      int p;
      int m;
      logic [ADDR_W-1:0] ad;
      p  = int'($urandom_range(0, 1));
      m  = int'($urandom_range(1, 3));
      ad = ADDR_W'($urandom_range(0, 15));
      write_word(p, ad, 9'($urandom), m[0], m[1]);
      read_word(1 - p, ad, d, bd, td);
      check("R1", "random lane mix", {bd, td, d}, {2'b11, model[ad]});
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_setup();
    t_mixed();
    t_writing_lane();
    t_stall_oe();
    t_deselect();
    t_collide();
    t_rd_during_wr();
    t_random();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule